// File: doc/BRIEF.md
# Auxiliary PWM Generator with Shadowed Period and Compare

This block drives a single PWM pin from a free-running time-stamp counter. The counter is compared against two working registers: a period value, where the counter folds back to zero, and a compare value, where the pin drops. Each working register has a backup copy, called its shadow. At every period boundary, meaning a cycle in which the counter equals the working period while counting in PWM mode, both working registers are refilled from their shadows. A running waveform therefore only changes shape at the start of a cycle.

Software sets new timing in one of two ways. It can write a working register directly. In PWM mode that write also lands in the matching shadow, so the change takes effect at once and survives the next refill. It can instead write a shadow only, and the new value then takes effect at the next boundary. Two control inputs run the block. One starts and stops the counter. The other selects PWM operation, and clearing it parks the pin low.

Top module: `aux_pwm_shadow`

## Requirements
- R1: While reset is asserted, and on release, the count output is 0 and the PWM pin is low. All working and shadow registers are 0 and both control bits are treated as cleared.
- R2: With the run input high, the count rises by one per clock unless R3 folds it. With the run input low, the count holds its value.
- R3: With PWM mode and run both high, a count equal to the working period is followed by a count of 0 on the next clock. With PWM mode low, the count folds only past all-ones.
- R4: With PWM mode high, after each clock the pin is high when the count is below the working compare value and low otherwise. So a compare value of 0 gives a constant low output, and a compare value above the period gives a constant high output.
- R5: When PWM mode is sampled low at a clock, the pin is low after that clock.
- R6: The write select codes are 00 working period, 01 working compare, 10 shadow period and 11 shadow compare. A write to a working register takes effect on the next clock. In PWM mode the same value also goes into that register's shadow, so it persists across boundaries.
- R7: A shadow write leaves the working register unchanged until the next period boundary. At that boundary the working register takes the written value.
- R8: At every period boundary both working registers are reloaded from their shadows, whether or not a shadow was written since the previous boundary.
- R9: With PWM mode low, a working-register write does not reach the shadow, and no boundary reload occurs.
- R10: If a shadow write falls on a boundary cycle, the working register loads the newly written value at that boundary. If a working-register write falls on a boundary cycle, the written value takes precedence over the reload.
- R11: With PWM mode high and run low, the count holds and the pin keeps its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Counter run control |
| pwm_en | input | 1 | PWM mode select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 working period, 01 working compare, 10 shadow period, 11 shadow compare |
| wr_data | input | W | Write data |
| tsc_o | output | W | Current counter value |
| pwm_o | output | 1 | PWM output pin |

## Verification
Two functions can coincide in one cycle: the boundary refill of the working registers, and a software write to a working or shadow register. The bench provokes this by waiting for its model count to equal the model period and then issuing a shadow-period write, and later a working-period write, on exactly that cycle. The random phase also produces such collisions by chance. Each collision is judged by the length of the following period, seen at the count output, and by the pin levels that follow, all compared against a reference model in the bench.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

   // write target encoding: bit 1 picks the shadow, bit 0 picks compare
   typedef enum logic [1:0] {
      SEL_ACT_PER = 2'b00,
      SEL_ACT_CMP = 2'b01,
      SEL_SHD_PER = 2'b10,
      SEL_SHD_CMP = 2'b11
   } wr_sel_e;

   localparam int SLOT_PER  = 0;
   localparam int SLOT_CMP  = 1;
   localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/aux_pwm_tsc.sv
module aux_pwm_tsc #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_en,
   input  logic         pwm_en,
   input  logic [W-1:0] period,
   output logic [W-1:0] count_q,
   output logic [W-1:0] count_d,
   output logic         boundary
);

   localparam logic [W-1:0] ONE = W'(1);

   // a boundary only exists while counting in PWM mode
   assign boundary = run_en & pwm_en & (count_q == period);

   always_comb begin
      if (!run_en)
         count_d = count_q;
      else if (boundary)
         count_d = '0;
      else
         count_d = count_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else
         count_q <= count_d;
   end

endmodule

// File: rtl/aux_pwm_slot.sv
module aux_pwm_slot #(
   parameter int W    = 32,
   parameter int SLOT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwm_en,
   input  logic         boundary,
   input  logic         wr_en,
   input  logic [1:0]   wr_sel,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] act_q,
   output logic [W-1:0] act_d,
   output logic [W-1:0] shd_q
);

   localparam logic SLOT_BIT = 1'(SLOT);

   logic         hit_act;
   logic         hit_shd;
   logic [W-1:0] shd_d;

   assign hit_act = wr_en & ~wr_sel[1] & (wr_sel[0] == SLOT_BIT);
   assign hit_shd = wr_en &  wr_sel[1] & (wr_sel[0] == SLOT_BIT);

   // working copy: a direct write wins, then the boundary refill, which
   // forwards a shadow write landing in the same cycle
   always_comb begin
      if (hit_act)
         act_d = wr_data;
      else if (boundary)
         act_d = hit_shd ? wr_data : shd_q;
      else
         act_d = act_q;
   end

   // shadow copy: its own write, or a mirror of a working write in PWM mode
   always_comb begin
      if (hit_shd)
         shd_d = wr_data;
      else if (hit_act && pwm_en)
         shd_d = wr_data;
      else
         shd_d = shd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         shd_q <= '0;
      end else begin
         act_q <= act_d;
         shd_q <= shd_d;
      end
   end

endmodule

// File: rtl/aux_pwm_wave.sv
module aux_pwm_wave #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwm_en,
   input  logic [W-1:0] count_d,
   input  logic [W-1:0] cmp_d,
   output logic         pwm_q
);

   // evaluated on next-state values so the pin lines up with the count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pwm_q <= 1'b0;
      else
         pwm_q <= pwm_en & (count_d < cmp_d);
   end

endmodule

// File: rtl/aux_pwm_shadow.sv
module aux_pwm_shadow #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_en,
   input  logic         pwm_en,
   input  logic         wr_en,
   input  logic [1:0]   wr_sel,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] tsc_o,
   output logic         pwm_o
);

   import aux_pwm_pkg::*;

   if (W < 2 || W > 64) begin : g_w_bad
      $error("aux_pwm_shadow: W must lie in 2..64");
   end

   logic [NUM_SLOTS-1:0][W-1:0] act_q;
   logic [NUM_SLOTS-1:0][W-1:0] act_d;
   logic [NUM_SLOTS-1:0][W-1:0] shd_q;
   logic [W-1:0]                count_q;
   logic [W-1:0]                count_d;
   logic                        boundary;

   aux_pwm_tsc #(.W(W)) u_tsc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .pwm_en   (pwm_en),
      .period   (act_q[SLOT_PER]),
      .count_q  (count_q),
      .count_d  (count_d),
      .boundary (boundary)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      aux_pwm_slot #(.W(W), .SLOT(s)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .pwm_en   (pwm_en),
         .boundary (boundary),
         .wr_en    (wr_en),
         .wr_sel   (wr_sel),
         .wr_data  (wr_data),
         .act_q    (act_q[s]),
         .act_d    (act_d[s]),
         .shd_q    (shd_q[s])
      );
   end

   aux_pwm_wave #(.W(W)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwm_en  (pwm_en),
      .count_d (count_d),
      .cmp_d   (act_d[SLOT_CMP]),
      .pwm_q   (pwm_o)
   );

   assign tsc_o = count_q;

endmodule

// File: rtl/aux_pwm_chk.sv
module aux_pwm_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run_en,
   input logic         pwm_en,
   input logic         wr_en,
   input logic [1:0]   wr_sel,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] tsc_o,
   input logic         pwm_o,
   input logic [W-1:0] act_per,
   input logic [W-1:0] act_cmp,
   input logic [W-1:0] shd_per,
   input logic [W-1:0] shd_cmp
);

   // R5
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en |=> !pwm_o);

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(tsc_o));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && !(pwm_en && tsc_o == act_per) |=> tsc_o == W'($past(tsc_o) + 1'b1));

   // R3
   period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && pwm_en && tsc_o == act_per |=> tsc_o == '0);

   // R6
   mirror_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && pwm_en && wr_sel == 2'b00 |=> act_per == $past(wr_data) && shd_per == $past(wr_data));

   // R9
   no_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en && !(wr_en && wr_sel[1]) |=> $stable(shd_per) && $stable(shd_cmp));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && pwm_en && tsc_o == act_per && !wr_en |=> act_per == $past(shd_per) && act_cmp == $past(shd_cmp));

   // R10
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && pwm_en && tsc_o == act_per && wr_en && wr_sel == 2'b10 |=> act_per == $past(wr_data));

endmodule

bind aux_pwm_shadow aux_pwm_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run_en  (run_en),
   .pwm_en  (pwm_en),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .tsc_o   (tsc_o),
   .pwm_o   (pwm_o),
   .act_per (act_q[0]),
   .act_cmp (act_q[1]),
   .shd_per (shd_q[0]),
   .shd_cmp (shd_q[1])
);

// File: tb/tb_aux_pwm_shadow.sv
`timescale 1ns/1ps
module tb_aux_pwm_shadow;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_en = 1'b0;
   logic         pwm_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'b00;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] tsc_o;
   logic         pwm_o;

   always #5 clk = ~clk;

   aux_pwm_shadow #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_en(pwm_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tsc_o(tsc_o), .pwm_o(pwm_o)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   logic [W-1:0] m_cnt, m_per, m_cmp, m_sper, m_scmp;
   logic         m_pwm;

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // reference model of one clock, built from the requirements
   task automatic model_clock(logic run, logic mode, logic we, logic [1:0] sel, logic [W-1:0] d);
      logic         tick;
      logic [W-1:0] nc, np, ncm, nsp, nsc;
      tick = mode && run && (m_cnt == m_per);
      nc   = !run ? m_cnt : (tick ? '0 : m_cnt + 1);
      np = m_per; ncm = m_cmp; nsp = m_sper; nsc = m_scmp;
      if (tick) begin np = m_sper; ncm = m_scmp; end
      if (we && sel[1]) begin
         if (sel[0]) begin nsc = d; if (tick) ncm = d; end
         else        begin nsp = d; if (tick) np  = d; end
      end
      if (we && !sel[1]) begin
         if (sel[0]) begin ncm = d; if (mode) nsc = d; end
         else        begin np  = d; if (mode) nsp = d; end
      end
      m_cnt = nc; m_per = np; m_cmp = ncm; m_sper = nsp; m_scmp = nsc;
      m_pwm = mode && (nc < ncm);
   endtask

   task automatic step(string tag, logic run, logic mode, logic we, logic [1:0] sel, logic [W-1:0] d);
      @(negedge clk);
      run_en = run; pwm_en = mode; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk);
      model_clock(run, mode, we, sel, d);
      #2;
      check(tag, tsc_o, m_cnt);
      check(tag, W'(pwm_o), W'(m_pwm));
   endtask

   task automatic idle(string tag, int n, logic run, logic mode);
      for (int i = 0; i < n; i++) step(tag, run, mode, 1'b0, 2'b00, '0);
   endtask

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0; run_en = 1'b0; pwm_en = 1'b0; wr_en = 1'b0; wr_sel = 2'b00; wr_data = '0;
      m_cnt = '0; m_per = '0; m_cmp = '0; m_sper = '0; m_scmp = '0; m_pwm = 1'b0;
      @(negedge clk);
      check("R1 count in reset", tsc_o, '0);
      check("R1 pin in reset", W'(pwm_o), '0);
      rst_n = 1'b1;
   endtask

   // advance in PWM mode until the model sits on a boundary
   task automatic wait_boundary(string tag);
      int guard = 0;
      while (m_cnt != m_per && guard < 64) begin
         step(tag, 1'b1, 1'b1, 1'b0, 2'b00, '0);
         guard++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int highs;
      reset_dut();

      // R9 / R8: working writes with mode clear are not mirrored, and the
      // first boundary refills from the zero shadows
      step("R9 act per no mirror", 1'b0, 1'b0, 1'b1, 2'b00, W'(4));
      step("R9 act cmp no mirror", 1'b0, 1'b0, 1'b1, 2'b01, W'(2));
      idle("R8 run to boundary", 5, 1'b1, 1'b1);
      idle("R8 refilled from zero shadow", 4, 1'b1, 1'b1);
      check("R8 count pinned at zero period", tsc_o, '0);
      check("R9 pin low after refill", W'(pwm_o), '0);

      // R3: outside PWM mode the period does not fold the count
      reset_dut();
      step("R3 act per in free mode", 1'b1, 1'b0, 1'b1, 2'b00, W'(3));
      idle("R3 free count", 6, 1'b1, 1'b0);
      check("R3 free count passes period", tsc_o, W'(7));

      // R7: shadow writes while stopped leave working regs alone
      reset_dut();
      step("R7 shadow per", 1'b0, 1'b1, 1'b1, 2'b10, W'(5));
      step("R7 shadow cmp", 1'b0, 1'b1, 1'b1, 2'b11, W'(2));
      check("R7 pin low before boundary", W'(pwm_o), '0);
      step("R8 start on boundary", 1'b1, 1'b1, 1'b0, 2'b00, '0);
      check("R8 count after start boundary", tsc_o, '0);
      check("R4 pin high below compare", W'(pwm_o), W'(1));
      idle("R4 waveform", 14, 1'b1, 1'b1);

      // R7: mid-period shadow write, old period completes first
      step("R7 shadow per mid period", 1'b1, 1'b1, 1'b1, 2'b10, W'(7));
      idle("R7 after shadow write", 20, 1'b1, 1'b1);

      // R6: working compare write, immediate and persistent
      step("R6 act cmp write", 1'b1, 1'b1, 1'b1, 2'b01, W'(4));
      idle("R6 persists over boundaries", 16, 1'b1, 1'b1);

      // R10: collisions on the boundary cycle
      wait_boundary("R10 seek boundary");
      step("R10 shadow write on boundary", 1'b1, 1'b1, 1'b1, 2'b10, W'(3));
      idle("R10 short period", 4, 1'b1, 1'b1);
      check("R10 period three folds", tsc_o, '0);
      idle("R10 after shadow collide", 6, 1'b1, 1'b1);
      wait_boundary("R10 seek boundary 2");
      step("R10 act write on boundary", 1'b1, 1'b1, 1'b1, 2'b00, W'(6));
      idle("R10 act write wins", 16, 1'b1, 1'b1);

      // R4 corners: compare above period, compare zero
      step("R4 cmp above period", 1'b1, 1'b1, 1'b1, 2'b01, W'(9));
      highs = 0;
      for (int i = 0; i < 16; i++) begin
         step("R4 constant high", 1'b1, 1'b1, 1'b0, 2'b00, '0);
         highs += int'(pwm_o);
      end
      check("R4 all cycles high", W'(highs), W'(16));
      step("R4 cmp zero", 1'b1, 1'b1, 1'b1, 2'b01, W'(0));
      idle("R4 constant low", 10, 1'b1, 1'b1);
      check("R4 pin low with zero compare", W'(pwm_o), '0);

      // R11: stall in PWM mode
      step("R11 cmp for stall", 1'b1, 1'b1, 1'b1, 2'b01, W'(3));
      idle("R11 stall", 6, 1'b0, 1'b1);
      check("R11 count held", tsc_o, m_cnt);

      // R5: mode cleared parks the pin low
      idle("R5 mode off", 4, 1'b1, 1'b0);
      check("R5 pin low", W'(pwm_o), '0);

      // constrained random segments
      for (int seg = 0; seg < 30; seg++) begin
         reset_dut();
         for (int i = 0; i < 300; i++) begin
            logic r, m, we;
            logic [1:0] s;
            logic [W-1:0] d;
            r  = ($urandom % 10) != 0;
            m  = ($urandom % 12) != 0;
            we = ($urandom % 4) == 0;
            s  = 2'($urandom);
            d  = W'($urandom % 13);
            step("R4 R10 random", r, m, we, s, d);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end

endmodule